// File: doc/BRIEF.md
# Chainable Two-Channel Edge-Aligned PWM

This block holds two byte-wide pulse-width modulator lanes. One is called the upper lane and the other the lower lane. Each lane has a free-running counter, a period and a duty value. Software sets up both lanes through a small byte-wide register port that has an address, a write strobe, a read strobe and registered read data. The block drives one pin per lane. An external prescaler supplies two clock-enable strobes. Strobe A paces the upper lane and strobe B paces the lower lane. The block also outputs the two prescaler selection fields so that the prescaler can use them.

When a control bit is set, the two lanes become one channel of twice the width. The upper lane's registers then hold the most significant byte and the lower lane's registers hold the least significant byte. Only strobe B paces the counter, and the waveform appears only on the lower pin. The upper pin is released: its output enable goes low and it is held low. Two mechanisms keep software views consistent. Reading the upper counter byte freezes a copy of the lower byte for the next read. Writing the lower counter byte restarts the whole counter. Period and duty are written into buffers, and each lane adopts the new values only at a period boundary or on a restart, so a period never starts with a partly updated value.

Top module: `pwm_pair8`

## Requirements
- R1: After a synchronous reset, the following hold: both pins are low, the upper-pin output enable is high, read data is zero, every counter and register reads zero, and both select outputs are zero.
- R2: The control register is at offset 0. Bit 6 chains the lanes, bits 5:4 drive `clk_sel_a`, and bits 2:0 drive `clk_sel_b`. Bits 7 and 3 always read as zero. The other offsets are: upper counter 1, lower counter 2, upper period 3, lower period 4, upper duty 5, lower duty 6. Read data appears on the cycle after the read strobe.
- R3: In separate mode, each lane's counter advances by one on each of its strobes, and the counter that reaches period−1 returns to 0 on the next strobe (period 0 gives 256 counts). The lane's pin is high while its counter is below its duty. The pin is registered and shows the count as it stood before the last clock edge.
- R4: A duty of 0 keeps a pin low for the entire period. A duty equal to or greater than the period keeps the pin high for the entire period.
- R5: A buffered period or duty is adopted only when the counter wraps or restarts. A duty written in the middle of a period leaves the rest of that period unchanged.
- R6: In chained mode the combined counter advances only on strobe B. Strobe A has no effect. The upper registers form the high byte of the counter, the period and the duty.
- R7: In chained mode the chained waveform is driven on the lower pin only. The upper pin is low and its output enable is low. Both return to normal when the lanes are separated again.
- R8: In chained mode, a read of the upper counter byte captures the lower byte at that moment. A read of the lower byte on the next cycle returns the captured value. Later reads of the lower byte return the live count.
- R9: A write to the lower counter byte clears the lower counter in separate mode and clears both bytes in chained mode. In separate mode, a write to the upper counter byte clears only the upper counter.
- R10: In chained mode, a write to the upper counter byte leaves the counter unchanged.
- R11: Changing the chain bit in either direction clears both counters and loads both lanes from their buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| tick_a | input | 1 | Prescaled enable for the upper lane |
| tick_b | input | 1 | Prescaled enable for the lower lane and for the chained channel |
| clk_sel_a | output | 2 | Prescaler selection A |
| clk_sel_b | output | 3 | Prescaler selection B |
| pwm_hi | output | 1 | Upper-lane pin |
| pwm_hi_oe | output | 1 | Upper-pin output enable |
| pwm_lo | output | 1 | Lower-lane pin, also the chained output |

## Verification
The bench builds the block with the default lane width of 8 bits, so the chained counter is 16 bits wide. At this width a chained period of 260 ticks carries the count across the byte boundary within a short run. A count that passes 0x01FF to 0x0200 exercises the snapshot read exactly as the lower byte rolls over. At the same width a period of 0 gives a full 256-count cycle that stays within the cycle budget.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CNT_H  = 3'd1,
    A_CNT_L  = 3'd2,
    A_PER_H  = 3'd3,
    A_PER_L  = 3'd4,
    A_DUTY_H = 3'd5,
    A_DUTY_L = 3'd6
  } reg_addr_e;

  localparam int CHAIN_BIT = 6;
  localparam int SELA_LSB  = 4;
  localparam int SELA_W    = 2;
  localparam int SELB_LSB  = 0;
  localparam int SELB_W    = 3;
  localparam int NLANE     = 2;
  localparam int LANE_LO   = 0;
  localparam int LANE_HI   = 1;
endpackage

// File: rtl/pwm_lane.sv
module pwm_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         inc,
  input  logic [W-1:0] per_buf,
  input  logic [W-1:0] duty_buf,
  output logic [W-1:0] cnt,
  output logic [W-1:0] per_act,
  output logic [W-1:0] duty_act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else if (load) begin
      cnt      <= '0;
      per_act  <= per_buf;
      duty_act <= duty_buf;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      cnt_h,
  input  logic [W-1:0]      cnt_l,
  output logic [W-1:0]      rdata,
  output logic              join_en,
  output logic [SELA_W-1:0] sel_a,
  output logic [SELB_W-1:0] sel_b,
  output logic [W-1:0]      per_h,
  output logic [W-1:0]      per_l,
  output logic [W-1:0]      duty_h,
  output logic [W-1:0]      duty_l,
  output logic              clr_h,
  output logic              clr_l
);
  logic [W-1:0] snap;
  logic         snap_vld;
  logic [W-1:0] ctrl_view;

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CHAIN_BIT] = join_en;
    ctrl_view[SELA_LSB +: SELA_W] = sel_a;
    ctrl_view[SELB_LSB +: SELB_W] = sel_b;
  end

  assign clr_l = wr_en && (addr == A_CNT_L);
  assign clr_h = wr_en && (addr == A_CNT_H) && !join_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      join_en <= 1'b0;
      sel_a   <= '0;
      sel_b   <= '0;
      per_h   <= '0;
      per_l   <= '0;
      duty_h  <= '0;
      duty_l  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          join_en <= wdata[CHAIN_BIT];
          sel_a   <= wdata[SELA_LSB +: SELA_W];
          sel_b   <= wdata[SELB_LSB +: SELB_W];
        end
        A_PER_H:  per_h  <= wdata;
        A_PER_L:  per_l  <= wdata;
        A_DUTY_H: duty_h <= wdata;
        A_DUTY_L: duty_l <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap     <= '0;
      snap_vld <= 1'b0;
      rdata    <= '0;
    end else begin
      snap_vld <= 1'b0;
      if (rd_en) begin
        case (addr)
          A_CTRL:   rdata <= ctrl_view;
          A_CNT_H: begin
            rdata <= cnt_h;
            if (join_en) begin
              snap     <= cnt_l;
              snap_vld <= 1'b1;
            end
          end
          A_CNT_L:  rdata <= snap_vld ? snap : cnt_l;
          A_PER_H:  rdata <= per_h;
          A_PER_L:  rdata <= per_l;
          A_DUTY_H: rdata <= duty_h;
          A_DUTY_L: rdata <= duty_l;
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         join_en,
  input  logic         tick_h,
  input  logic         tick_l,
  input  logic         clr_h,
  input  logic         clr_l,
  input  logic [W-1:0] per_h,
  input  logic [W-1:0] per_l,
  input  logic [W-1:0] duty_h,
  input  logic [W-1:0] duty_l,
  output logic [W-1:0] cnt_h,
  output logic [W-1:0] cnt_l,
  output logic         raw_h,
  output logic         raw_l
);
  localparam int DW = 2 * W;

  logic [W-1:0] per_b  [NLANE];
  logic [W-1:0] duty_b [NLANE];
  logic [W-1:0] cnt_v  [NLANE];
  logic [W-1:0] pa_v   [NLANE];
  logic [W-1:0] da_v   [NLANE];
  logic         ld_v   [NLANE];
  logic         inc_v  [NLANE];

  logic          join_q;
  logic          toggle;
  logic [DW-1:0] c_wide, p_wide, d_wide;
  logic          wrap_h, wrap_l, wrap_w;

  assign per_b[LANE_LO]  = per_l;
  assign per_b[LANE_HI]  = per_h;
  assign duty_b[LANE_LO] = duty_l;
  assign duty_b[LANE_HI] = duty_h;
  assign cnt_l = cnt_v[LANE_LO];
  assign cnt_h = cnt_v[LANE_HI];

  always_ff @(posedge clk) begin
    if (rst) join_q <= 1'b0;
    else     join_q <= join_en;
  end

  assign toggle = join_en ^ join_q;
  assign c_wide = {cnt_v[LANE_HI], cnt_v[LANE_LO]};
  assign p_wide = {pa_v[LANE_HI], pa_v[LANE_LO]};
  assign d_wide = {da_v[LANE_HI], da_v[LANE_LO]};
  assign wrap_h = (cnt_v[LANE_HI] == pa_v[LANE_HI] - 1'b1);
  assign wrap_l = (cnt_v[LANE_LO] == pa_v[LANE_LO] - 1'b1);
  assign wrap_w = (c_wide == p_wide - 1'b1);

  always_comb begin
    ld_v[LANE_LO]  = toggle || clr_l || (tick_l && (join_en ? wrap_w : wrap_l));
    inc_v[LANE_LO] = !ld_v[LANE_LO] && tick_l;
    if (join_en) begin
      ld_v[LANE_HI]  = toggle || clr_l || (tick_l && wrap_w);
      inc_v[LANE_HI] = !ld_v[LANE_HI] && tick_l && (cnt_v[LANE_LO] == '1);
    end else begin
      ld_v[LANE_HI]  = toggle || clr_h || (tick_h && wrap_h);
      inc_v[LANE_HI] = !ld_v[LANE_HI] && tick_h;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    pwm_lane #(.W(W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .load     (ld_v[g]),
      .inc      (inc_v[g]),
      .per_buf  (per_b[g]),
      .duty_buf (duty_b[g]),
      .cnt      (cnt_v[g]),
      .per_act  (pa_v[g]),
      .duty_act (da_v[g])
    );
  end

  assign raw_l = join_en ? (c_wide < d_wide) : (cnt_v[LANE_LO] < da_v[LANE_LO]);
  assign raw_h = cnt_v[LANE_HI] < da_v[LANE_HI];
endmodule

// File: rtl/pwm_pins.sv
module pwm_pins (
  input  logic clk,
  input  logic rst,
  input  logic join_en,
  input  logic raw_h,
  input  logic raw_l,
  output logic pwm_hi,
  output logic pwm_hi_oe,
  output logic pwm_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_hi    <= 1'b0;
      pwm_hi_oe <= 1'b1;
      pwm_lo    <= 1'b0;
    end else begin
      pwm_lo    <= raw_l;
      pwm_hi    <= join_en ? 1'b0 : raw_h;
      pwm_hi_oe <= !join_en;
    end
  end
endmodule

// File: rtl/pwm_pair8.sv
module pwm_pair8
  import pwm_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              tick_a,
  input  logic              tick_b,
  output logic [SELA_W-1:0] clk_sel_a,
  output logic [SELB_W-1:0] clk_sel_b,
  output logic              pwm_hi,
  output logic              pwm_hi_oe,
  output logic              pwm_lo
);
  logic         join_en;
  logic         clr_h, clr_l;
  logic         raw_h, raw_l;
  logic [W-1:0] cnt_h, cnt_l;
  logic [W-1:0] per_h, per_l, duty_h, duty_l;

  pwm_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr_en   (bus_wr),
    .rd_en   (bus_rd),
    .wdata   (bus_wdata),
    .cnt_h   (cnt_h),
    .cnt_l   (cnt_l),
    .rdata   (bus_rdata),
    .join_en (join_en),
    .sel_a   (clk_sel_a),
    .sel_b   (clk_sel_b),
    .per_h   (per_h),
    .per_l   (per_l),
    .duty_h  (duty_h),
    .duty_l  (duty_l),
    .clr_h   (clr_h),
    .clr_l   (clr_l)
  );

  pwm_core #(.W(W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .join_en (join_en),
    .tick_h  (tick_a),
    .tick_l  (tick_b),
    .clr_h   (clr_h),
    .clr_l   (clr_l),
    .per_h   (per_h),
    .per_l   (per_l),
    .duty_h  (duty_h),
    .duty_l  (duty_l),
    .cnt_h   (cnt_h),
    .cnt_l   (cnt_l),
    .raw_h   (raw_h),
    .raw_l   (raw_l)
  );

  pwm_pins u_pins (
    .clk       (clk),
    .rst       (rst),
    .join_en   (join_en),
    .raw_h     (raw_h),
    .raw_l     (raw_l),
    .pwm_hi    (pwm_hi),
    .pwm_hi_oe (pwm_hi_oe),
    .pwm_lo    (pwm_lo)
  );
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         join_en,
  input logic         tick_b,
  input logic         clr_l,
  input logic [W-1:0] cnt_h,
  input logic [W-1:0] cnt_l,
  input logic         pwm_hi,
  input logic         pwm_hi_oe
);
  // R3: in separate mode the lower counter steps by one or wraps to zero
  assert_lo_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(join_en) && !$past(join_en, 2)
     && $past(tick_b) && !$past(clr_l))
    |-> (cnt_l == $past(cnt_l) + 1'b1 || cnt_l == '0));

  // R6: chained upper byte holds still without a lower strobe
  assert_hi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(join_en) && $past(join_en, 2)
     && !$past(tick_b) && !$past(clr_l))
    |-> $stable(cnt_h));

  // R7: upper pin released while chained
  assert_hi_free_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(join_en)) |-> (!pwm_hi && !pwm_hi_oe));

  // R9: lower counter write restarts the count
  assert_lo_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr_l)) |-> (cnt_l == '0));

  // R11: changing the chain bit clears both counters
  assert_toggle_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && ($past(join_en) != $past(join_en, 2)))
    |-> (cnt_h == '0 && cnt_l == '0));
endmodule

bind pwm_pair8 pwm_pair_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .join_en   (join_en),
  .tick_b    (tick_b),
  .clr_l     (clr_l),
  .cnt_h     (cnt_h),
  .cnt_l     (cnt_l),
  .pwm_hi    (pwm_hi),
  .pwm_hi_oe (pwm_hi_oe)
);

// File: tb/tb_pwm_pair8.sv
module tb_pwm_pair8;
  localparam int W = 8;
  localparam logic [2:0] O_CTRL = 3'd0, O_CNTH = 3'd1, O_CNTL = 3'd2,
                         O_PERH = 3'd3, O_PERL = 3'd4, O_DUTH = 3'd5, O_DUTL = 3'd6;

  // table: lane (0 lower / 1 upper), period, duty, expected high counts per period
  localparam int NV = 7;
  localparam int V_CH  [NV] = '{0, 0, 0, 1, 1, 0, 0};
  localparam int V_PER [NV] = '{10, 10, 10, 7, 5, 0, 1};
  localparam int V_DUTY[NV] = '{3, 0, 10, 200, 4, 128, 1};
  localparam int V_HI  [NV] = '{3, 0, 10, 7, 4, 128, 1};

  logic clk = 0, rst = 1;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic tick_a = 0, tick_b = 0;
  logic [1:0] clk_sel_a;
  logic [2:0] clk_sel_b;
  logic pwm_hi, pwm_hi_oe, pwm_lo;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pwm_pair8 #(.W(W)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = W'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = int'(bus_rdata);
  endtask

  task automatic run_chk(input int ch, input int eff, input int hi, input int n, input string tag);
    if (ch == 0) tick_b = 1; else tick_a = 1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(tag, ch == 0 ? int'(pwm_lo) : int'(pwm_hi), ((k % eff) < hi) ? 1 : 0);
    end
    tick_a = 0; tick_b = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v, eff;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_lo", pwm_lo, 0);
    chk("R1 pwm_hi", pwm_hi, 0);
    chk("R1 oe", pwm_hi_oe, 1);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 sel", {clk_sel_a, clk_sel_b}, 0);
    rd(O_CTRL, v); chk("R1 ctrl", v, 0);
    rd(O_CNTL, v); chk("R1 cnt", v, 0);

    // table walk: R3 and R4 in separate mode
    for (int i = 0; i < NV; i++) begin
      eff = (V_PER[i] == 0) ? 256 : V_PER[i];
      wr(V_CH[i] == 0 ? O_PERL : O_PERH, V_PER[i]);
      wr(V_CH[i] == 0 ? O_DUTL : O_DUTH, V_DUTY[i]);
      wr(V_CH[i] == 0 ? O_CNTL : O_CNTH, 0);
      run_chk(V_CH[i], eff, V_HI[i], 2 * eff, "R3 R4 table");
    end

    // R5: a duty written mid-period waits for the wrap
    wr(O_PERL, 8); wr(O_DUTL, 2); wr(O_CNTL, 0);
    tick_b = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R5 before", pwm_lo, (k < 2) ? 1 : 0);
    end
    tick_b = 0;
    wr(O_DUTL, 6);
    chk("R5 idle", pwm_lo, 0);
    tick_b = 1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R5 after", pwm_lo, (k >= 4 && k < 10) ? 1 : 0);
    end
    tick_b = 0;

    // R6/R7: chained 16-bit channel, strobe A ignored
    wr(O_CTRL, 8'h40);
    wr(O_PERH, 8'h01); wr(O_PERL, 8'h04);
    wr(O_DUTH, 8'h01); wr(O_DUTL, 8'h02);
    wr(O_CNTL, 0);
    tick_a = 1;
    run_chk(0, 260, 258, 300, "R6 chained");
    chk("R7 hi pin", pwm_hi, 0);
    chk("R7 hi oe", pwm_hi_oe, 0);
    tick_a = 1;
    repeat (5) @(negedge clk);
    tick_a = 0;
    rd(O_CNTH, v); chk("R6 hi after tick_a", v, 0);
    rd(O_CNTL, v); chk("R6 lo after tick_a", v, 40);

    // R8: coherent read as the low byte rolls 0x1FF -> 0x200
    wr(O_PERH, 8'h03); wr(O_PERL, 8'h00); wr(O_CNTL, 0);
    tick_b = 1;
    repeat (511) @(negedge clk);
    bus_rd = 1; bus_addr = O_CNTH;
    @(negedge clk);
    chk("R8 hi byte", bus_rdata, 1);
    tick_b = 0; bus_addr = O_CNTL;
    @(negedge clk);
    bus_rd = 0;
    chk("R8 held lo", bus_rdata, 8'hFF);
    rd(O_CNTL, v); chk("R8 live lo", v, 0);
    rd(O_CNTH, v); chk("R8 live hi", v, 2);

    // R10: upper counter write ignored when chained
    wr(O_CNTH, 8'h55);
    rd(O_CNTH, v); chk("R10 hi", v, 2);
    // R9: lower write clears all 16 bits
    wr(O_CNTL, 8'h12);
    rd(O_CNTH, v); chk("R9 wide hi", v, 0);
    rd(O_CNTL, v); chk("R9 wide lo", v, 0);

    // R11: leaving chained mode clears the counter
    tick_b = 1; repeat (20) @(negedge clk); tick_b = 0;
    rd(O_CNTL, v); chk("R11 pre", v, 20);
    wr(O_CTRL, 8'h00);
    rd(O_CNTL, v); chk("R11 lo", v, 0);
    rd(O_CNTH, v); chk("R11 hi", v, 0);
    chk("R7 oe back", pwm_hi_oe, 1);

    // R9: separate-mode clears touch one lane
    wr(O_PERH, 8'h40); wr(O_PERL, 8'h40);
    wr(O_CNTH, 0); wr(O_CNTL, 0);
    tick_a = 1; tick_b = 1;
    repeat (4) @(negedge clk);
    tick_b = 0;
    repeat (5) @(negedge clk);
    tick_a = 0;
    wr(O_CNTL, 0);
    rd(O_CNTH, v); chk("R9 hi kept", v, 9);
    rd(O_CNTL, v); chk("R9 lo cleared", v, 0);
    wr(O_CNTH, 0);
    rd(O_CNTH, v); chk("R9 hi cleared", v, 0);

    // R2: control layout and reserved bits
    wr(O_CTRL, 8'hFF);
    rd(O_CTRL, v); chk("R2 mask", v, 8'h77);
    chk("R2 sel a", clk_sel_a, 3);
    chk("R2 sel b", clk_sel_b, 7);
    wr(O_CTRL, 8'h25);
    rd(O_CTRL, v); chk("R2 value", v, 8'h25);
    chk("R2 sel a2", clk_sel_a, 2);
    chk("R2 sel b2", clk_sel_b, 5);
    rd(O_DUTH, v); chk("R2 duty hi", v, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule